// File: doc/BRIEF.md
# DMA Channel Address Stepper with Circular Wrap

This block holds the running source or destination address of one DMA channel and steps it as the transfer advances. A channel uses two copies, one for reads and one for writes. The copy is told through single-cycle strobes when one access has finished, when a minor loop has finished and when the whole major loop is over. Each strobe adds its own signed quantity to the address: the per-access stride, an optional per-minor-loop jump, or the end-of-transfer correction. When the strobes coincide, their quantities are summed and applied in one step.

A power-of-two circular buffer is formed by a wrap code. When the code is nonzero, only the low bits of the address take the new sum. The bits above them stay exactly as they were, so the address cycles inside an aligned window. The same wrap applies to every kind of update. A load strobe writes a fresh base address and takes precedence over all stepping in that cycle. The block also decodes the access-size code into a byte count for the bus side.

Top module: `dma_addr_gen`

## Requirements
- R1: When `load_en` is high at a clock edge, `addr_q` takes `load_addr` on that edge, whatever strobes are also high.
- R2: When `acc_done` is high (and `load_en` low), the 16-bit signed `acc_off` is sign-extended and added to `addr_q` at that edge. The sum wraps modulo 2^ADDR_W.
- R3: For `mod_code` = n with 1 <= n <= 31, the low n bits of the new address are the low n bits of (address + total step), and bits n and above keep their previous value. `mod_code` = 0 applies no wrap.
- R4: When `minor_done` is high and `minor_off_en` is high, the signed `minor_off` is sign-extended and added to the address. When `minor_off_en` is low, `minor_done` leaves the address unchanged.
- R5: Strobes that are high in the same cycle each contribute their quantity, and the summed step is applied once, then wrapped as in R3.
- R6: When `major_done` is high, the signed `last_adj` is added to the address, and the wrap of R3 applies to the result.
- R7: `beat_bytes` equals 2^`size_code` for codes 0 to 6 and is 0 for code 7. `wide_beat` is high exactly for codes 5 and 6 (32 bytes or more).
- R8: Synchronous active-high `rst` sets `addr_q` to 0.
- R9: In a cycle with no load and no strobes, `addr_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write `load_addr` into the address register |
| load_addr | input | ADDR_W | New base address |
| acc_done | input | 1 | One access has completed |
| minor_done | input | 1 | One minor loop has completed |
| major_done | input | 1 | The major loop has completed |
| acc_off | input | OFF_W | Signed per-access stride |
| size_code | input | 3 | Access size code |
| mod_code | input | 5 | Circular window size code, 0 = no wrap |
| minor_off_en | input | 1 | Enable the per-minor-loop jump |
| minor_off | input | MOFF_W | Signed per-minor-loop jump |
| last_adj | input | ADDR_W | Signed end-of-transfer correction |
| addr_q | output | ADDR_W | Current address |
| beat_bytes | output | 7 | Bytes per access decoded from `size_code` |
| wide_beat | output | 1 | Access is 32 bytes or wider |

## Verification
The last access of a minor loop falls in the same cycle as the minor-loop strobe, and at the end of a transfer the major-loop strobe joins them. The bench raises `acc_done` with `minor_done`, and then all three strobes together, under several wrap codes. It judges the result against a bench model that applies the summed step to the in-window offset with integer modulo arithmetic. It also raises `load_en` alongside all strobes to confirm the load wins.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

    localparam int SIZE_W  = 3;
    localparam int MOD_W   = 5;
    localparam int BEAT_W  = 7;
    localparam int MAX_SIZE_CODE = 6;
    localparam int WIDE_SIZE_CODE = 5;

    // One strobe per kind of address event
    typedef struct packed {
        logic acc;
        logic minor;
        logic major;
    } step_evt_t;

    // Byte count of one access; reserved code gives zero
    function automatic logic [BEAT_W-1:0] beat_width(input logic [SIZE_W-1:0] code);
        logic [BEAT_W-1:0] w;
        w = '0;
        if (int'(code) <= MAX_SIZE_CODE)
            w[code] = 1'b1;
        return w;
    endfunction

    function automatic logic is_wide(input logic [SIZE_W-1:0] code);
        return (int'(code) >= WIDE_SIZE_CODE) && (int'(code) <= MAX_SIZE_CODE);
    endfunction

endpackage

// File: rtl/beat_size_decode.sv
module beat_size_decode
    import dma_addr_pkg::*;
(
    input  logic [SIZE_W-1:0] size_code,
    output logic [BEAT_W-1:0] beat_bytes,
    output logic              wide_beat
);

    always_comb begin
        beat_bytes = beat_width(size_code);
        wide_beat  = is_wide(size_code);
    end

endmodule

// File: rtl/addr_step_sum.sv
module addr_step_sum
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int MOFF_W = 20
) (
    input  step_evt_t                 evt,
    input  logic signed [OFF_W-1:0]   acc_off,
    input  logic                      minor_off_en,
    input  logic signed [MOFF_W-1:0]  minor_off,
    input  logic signed [ADDR_W-1:0]  last_adj,
    output logic [ADDR_W-1:0]         step
);

    logic signed [ADDR_W-1:0] acc_term;
    logic signed [ADDR_W-1:0] minor_term;
    logic signed [ADDR_W-1:0] major_term;

    always_comb begin
        acc_term   = evt.acc ? ADDR_W'(acc_off) : '0;
        minor_term = (evt.minor && minor_off_en) ? ADDR_W'(minor_off) : '0;
        major_term = evt.major ? last_adj : '0;
        step       = acc_term + minor_term + major_term;
    end

endmodule

// File: rtl/addr_wrap_merge.sv
module addr_wrap_merge
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] step,
    input  logic [MOD_W-1:0]  mod_code,
    output logic [ADDR_W-1:0] next_addr
);

    logic [ADDR_W-1:0] raw_sum;
    logic [ADDR_W-1:0] window;

    // Bit i follows the sum when wrap is off or i lies inside the window
    for (genvar i = 0; i < ADDR_W; i++) begin : g_window
        assign window[i] = (mod_code == '0) || ({1'b0, mod_code} > (MOD_W+1)'(i));
    end

    always_comb begin
        raw_sum   = cur_addr + step;
        next_addr = (raw_sum & window) | (cur_addr & ~window);
    end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int MOFF_W = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_en,
    input  logic [ADDR_W-1:0]        load_addr,
    input  logic                     acc_done,
    input  logic                     minor_done,
    input  logic                     major_done,
    input  logic signed [OFF_W-1:0]  acc_off,
    input  logic [SIZE_W-1:0]        size_code,
    input  logic [MOD_W-1:0]         mod_code,
    input  logic                     minor_off_en,
    input  logic signed [MOFF_W-1:0] minor_off,
    input  logic signed [ADDR_W-1:0] last_adj,
    output logic [ADDR_W-1:0]        addr_q,
    output logic [BEAT_W-1:0]        beat_bytes,
    output logic                     wide_beat
);

    step_evt_t         evt;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] next_addr;
    logic              any_evt;

    always_comb begin
        evt.acc   = acc_done;
        evt.minor = minor_done;
        evt.major = major_done;
        any_evt   = acc_done | minor_done | major_done;
    end

    addr_step_sum #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .MOFF_W (MOFF_W)
    ) u_sum (
        .evt          (evt),
        .acc_off      (acc_off),
        .minor_off_en (minor_off_en),
        .minor_off    (minor_off),
        .last_adj     (last_adj),
        .step         (step)
    );

    addr_wrap_merge #(
        .ADDR_W (ADDR_W)
    ) u_wrap (
        .cur_addr  (addr_q),
        .step      (step),
        .mod_code  (mod_code),
        .next_addr (next_addr)
    );

    beat_size_decode u_size (
        .size_code  (size_code),
        .beat_bytes (beat_bytes),
        .wide_beat  (wide_beat)
    );

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load_en)
            addr_q <= load_addr;
        else if (any_evt)
            addr_q <= next_addr;
    end

endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk
    import dma_addr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MOFF_W = 20
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     load_en,
    input logic [ADDR_W-1:0]        load_addr,
    input logic                     acc_done,
    input logic                     minor_done,
    input logic                     major_done,
    input logic                     minor_off_en,
    input logic signed [MOFF_W-1:0] minor_off,
    input logic [SIZE_W-1:0]        size_code,
    input logic [MOD_W-1:0]         mod_code,
    input logic [ADDR_W-1:0]        addr_q,
    input logic [BEAT_W-1:0]        beat_bytes,
    input logic                     wide_beat
);

    logic [ADDR_W-1:0] frozen;

    always_comb begin
        for (int i = 0; i < ADDR_W; i++)
            frozen[i] = (mod_code != '0) && (i >= int'(mod_code));
    end

    // R1: load wins over every strobe
    a_r1_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_en |=> addr_q == $past(load_addr));

    // R9: no event, no change
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !acc_done && !minor_done && !major_done) |=> $stable(addr_q));

    // R3: bits above the window never move on a step
    a_r3_upper_frozen: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> ((addr_q ^ $past(addr_q)) & $past(frozen)) == '0);

    // R4: disabled minor jump alone leaves the address
    a_r4_minor_gated: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !acc_done && !major_done && minor_done && !minor_off_en) |=> $stable(addr_q));

    // R4: zero-valued minor jump alone leaves the address
    a_r4_minor_zero: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !acc_done && !major_done && minor_done && minor_off == '0) |=> $stable(addr_q));

    // R7: a single size bit at most, and the wide flag only for 32 or 64 bytes
    a_r7_beat_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(beat_bytes));
    a_r7_wide_match: assert property (@(posedge clk) disable iff (rst)
        wide_beat |-> (beat_bytes[5] || beat_bytes[6]));
    a_r7_reserved_code: assert property (@(posedge clk) disable iff (rst)
        (size_code == 3'd7) |-> (beat_bytes == '0 && !wide_beat));

    // R8: reset clears the address
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> addr_q == '0);

endmodule

bind dma_addr_gen dma_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .MOFF_W (MOFF_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .load_en      (load_en),
    .load_addr    (load_addr),
    .acc_done     (acc_done),
    .minor_done   (minor_done),
    .major_done   (major_done),
    .minor_off_en (minor_off_en),
    .minor_off    (minor_off),
    .size_code    (size_code),
    .mod_code     (mod_code),
    .addr_q       (addr_q),
    .beat_bytes   (beat_bytes),
    .wide_beat    (wide_beat)
);

// File: tb/dma_addr_gen_tb.sv
`timescale 1ns/1ps
module dma_addr_gen_tb;

    localparam int AW = 32;
    localparam int OW = 16;
    localparam int MW = 20;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 load_en;
    logic [AW-1:0]        load_addr;
    logic                 acc_done, minor_done, major_done;
    logic signed [OW-1:0] acc_off;
    logic [2:0]           size_code;
    logic [4:0]           mod_code;
    logic                 minor_off_en;
    logic signed [MW-1:0] minor_off;
    logic signed [AW-1:0] last_adj;
    logic [AW-1:0]        addr_q;
    logic [6:0]           beat_bytes;
    logic                 wide_beat;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] model;

    always #2.5 clk = ~clk;

    dma_addr_gen #(.ADDR_W(AW), .OFF_W(OW), .MOFF_W(MW)) u_dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .acc_done(acc_done), .minor_done(minor_done), .major_done(major_done),
        .acc_off(acc_off), .size_code(size_code), .mod_code(mod_code),
        .minor_off_en(minor_off_en), .minor_off(minor_off), .last_adj(last_adj),
        .addr_q(addr_q), .beat_bytes(beat_bytes), .wide_beat(wide_beat)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Window arithmetic: keep the block base, move the in-window offset modulo 2^n
    function automatic logic [AW-1:0] predict(input logic [AW-1:0] cur, input longint delta, input int n);
        longint m, lo, base, lo2;
        if (n == 0) return AW'(longint'(cur) + delta);
        m    = longint'(1) << n;
        lo   = longint'(cur) % m;
        base = longint'(cur) - lo;
        lo2  = (((lo + delta) % m) + m) % m;
        return AW'(base + lo2);
    endfunction

    task automatic op(input logic ld, input logic a, input logic mi, input logic ma, input string req);
        longint d;
        d = 0;
        if (a) d += longint'(acc_off);
        if (mi && minor_off_en) d += longint'(minor_off);
        if (ma) d += longint'(last_adj);
        @(negedge clk);
        load_en = ld; acc_done = a; minor_done = mi; major_done = ma;
        @(negedge clk);
        load_en = 0; acc_done = 0; minor_done = 0; major_done = 0;
        if (ld) model = load_addr;
        else if (a || mi || ma) model = predict(model, d, int'(mod_code));
        check(req, addr_q, model);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int mods[12] = '{0, 1, 2, 3, 4, 5, 6, 8, 10, 16, 24, 31};
        int offs[6]  = '{1, -1, 3, -7, 40, -300};
        rst = 1; load_en = 0; load_addr = '0; acc_done = 0; minor_done = 0; major_done = 0;
        acc_off = '0; size_code = '0; mod_code = '0; minor_off_en = 0; minor_off = '0; last_adj = '0;
        repeat (3) @(negedge clk);
        check("R8 reset", addr_q, '0);
        rst = 0;
        model = '0;

        // R7 size decode sweep
        for (int c = 0; c < 8; c++) begin
            size_code = 3'(c);
            #1;
            check("R7 beat_bytes", AW'(beat_bytes), (c <= 6) ? AW'(1 << c) : '0);
            check("R7 wide_beat", AW'(wide_beat), AW'(c == 5 || c == 6));
        end

        // R9 idle
        op(0, 0, 0, 0, "R9 idle hold");
        // R2 plain stride with full-width wrap
        load_addr = 32'h0000_0000; op(1, 0, 0, 0, "R1 load");
        acc_off = -16'sd1; op(0, 1, 0, 0, "R2 negative wrap below zero");
        acc_off = 16'sh7FFF; op(0, 1, 0, 0, "R2 max positive stride");
        acc_off = -16'sh8000; op(0, 1, 0, 0, "R2 max negative stride");

        // R3 window sweep with strides
        for (int mi = 0; mi < 12; mi++) begin
            mod_code = 5'(mods[mi]);
            load_addr = 32'hA5C3_7E15;
            op(1, 0, 0, 0, "R1 load");
            for (int k = 0; k < 6; k++) begin
                acc_off = OW'(offs[k]);
                op(0, 1, 0, 0, "R3 wrapped stride");
            end
        end

        // R4 minor jump enabled / disabled
        mod_code = 0; load_addr = 32'h1000_0000; op(1, 0, 0, 0, "R1 load");
        minor_off = -20'sd4096; minor_off_en = 1; op(0, 0, 1, 0, "R4 minor jump enabled");
        minor_off_en = 0; op(0, 0, 1, 0, "R4 minor jump disabled ignored");

        // R5 coincident strobes under several windows
        for (int mi = 0; mi < 12; mi++) begin
            mod_code = 5'(mods[mi]);
            minor_off_en = 1;
            load_addr = 32'h3C3C_0F0F; op(1, 0, 0, 0, "R1 load");
            acc_off = 16'sd8; minor_off = 20'sd100;
            op(0, 1, 1, 0, "R5 access plus minor");
            acc_off = -16'sd2; minor_off = -20'sd33; last_adj = -32'sd1000;
            op(0, 1, 1, 1, "R5 all three strobes");
            last_adj = 32'sd77;
            op(0, 0, 0, 1, "R6 last adjust wrapped");
        end

        // R1 load overrides all strobes
        mod_code = 3; load_addr = 32'hDEAD_BEEF;
        op(1, 1, 1, 1, "R1 load overrides strobes");
        op(0, 0, 0, 0, "R9 idle hold after load");

        // R8 reset mid-run
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        check("R8 reset mid-run", addr_q, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule